// File: doc/BRIEF.md
# Programmable AND-Array Logic with Output Feedback

This block is a small sum-of-products array. The AND plane is programmable. The OR plane is fixed. There are four primary inputs and four output sections. Each section ORs its own group of three product terms. No product term can be shared between sections, and no section can take more terms than its group holds.

To build functions wider than one section, every output is also offered to the AND plane as an extra literal in both polarities. Feedback only works from a lower-numbered output to a higher-numbered one. Any select that would take a section's own output, or a later output, is cleared in hardware when the configuration is loaded. This keeps the array free of combinational loops, whatever bit pattern is programmed.

The configuration works like a fuse map. It is shifted in one bit per clock into a staging register. A load strobe then copies the staging register into the active array. Shifting alone never disturbs the active configuration.

Top module: `pal_fb_array`

## Requirements
- R1: After reset, every product term holds both polarities of input literal 0, so all outputs read 0 until the first load.
- R2: While `cfg_shift` is high, `cfg_din` enters staging bit 0 on each clock edge and the staging register moves one place toward its MSB. After 192 shifts, the first bit sent sits at bit 191.
- R3: The bit layout of the configuration is as follows. Product term p occupies bits 16p+15 down to 16p. Literal l uses bit 16p+2l for its true select and bit 16p+2l+1 for its complement select. Literals 0 to 3 are `in_pins[0..3]`, and literals 4 to 7 are `out_pins[0..3]`. Section s owns product terms 3s, 3s+1 and 3s+2.
- R4: Shifting without `cfg_load` has no effect on the outputs.
- R5: When `cfg_load` is sampled high, the staging contents (before any shift in that same cycle) become active, and the outputs follow the new configuration from that edge on.
- R6: A product term is the AND of its selected literals. A term with no select set is constant 1. A term that selects both polarities of one literal is constant 0.
- R7: Each output is the OR of the three product terms of its own section only.
- R8: A product term in section s may use outputs 0 to s-1 as literals. A term in section 3 can therefore be driven by output 0.
- R9: Selects in section s that point at outputs s to 3 are forced to 0 at load and have no effect on any output.
- R10: The array can realise the reference set, with in_pins[3] as the MSB: W=Σm(2,12,13), X=Σm(7..15), Y=Σm(0,2,3,4,5,6,7,8,10,11,15) and Z=Σm(1,2,8,12,13). Z uses W through feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 1 | Shift `cfg_din` into the staging register |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copy staging into the active array |
| in_pins | input | 4 | Primary inputs (bit 3 = A, bit 0 = D) |
| out_pins | output | 4 | Section outputs (bit 0 = W ... bit 3 = Z) |

## Verification
Four things are checked on every cycle. The outputs stay 0 between reset and the first load. The active array changes only on the cycle after a load. A load copies the staging bits. No select from a section's own output, or a later one, ever sits in the active array. Only the bench scenarios can show the rest, because they depend on the programmed contents: the shift order and bit layout, the AND/OR evaluation with the constant-0 and constant-1 term cases, chaining through feedback, and the correct minterm sets of the reference functions.

// File: rtl/pal_fb_array.sv
`timescale 1ns/1ps
module pal_fb_array #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int PT_PER = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  in_pins,
  output logic [N_OUT-1:0] out_pins
);
  localparam int N_LIT    = N_IN + N_OUT;
  localparam int PT_BITS  = 2 * N_LIT;
  localparam int N_PT     = N_OUT * PT_PER;
  localparam int CFG_BITS = N_PT * PT_BITS;

  function automatic logic [CFG_BITS-1:0] fb_mask();
    logic [CFG_BITS-1:0] m;
    m = '1;
    for (int p = 0; p < N_PT; p++)
      for (int j = p / PT_PER; j < N_OUT; j++) begin
        m[p*PT_BITS + 2*(N_IN+j)]     = 1'b0;
        m[p*PT_BITS + 2*(N_IN+j) + 1] = 1'b0;
      end
    return m;
  endfunction

  function automatic logic [CFG_BITS-1:0] zero_cfg();
    logic [CFG_BITS-1:0] c;
    c = '0;
    for (int p = 0; p < N_PT; p++) begin
      c[p*PT_BITS]     = 1'b1;
      c[p*PT_BITS + 1] = 1'b1;
    end
    return c;
  endfunction

  localparam logic [CFG_BITS-1:0] FB_MASK = fb_mask();
  localparam logic [CFG_BITS-1:0] RST_CFG = zero_cfg();

  logic [CFG_BITS-1:0] shift_q;
  logic [CFG_BITS-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q  <= '0;
      active_q <= RST_CFG;
    end else begin
      if (cfg_shift) shift_q  <= {shift_q[CFG_BITS-2:0], cfg_din};
      if (cfg_load)  active_q <= shift_q & FB_MASK;
    end
  end

  logic [N_OUT-1:0] sec_val;
  logic [N_LIT-1:0] lits;
  logic             acc;
  logic             term;

  always_comb begin
    sec_val = '0;
    lits    = '0;
    acc     = 1'b0;
    term    = 1'b0;
    for (int s = 0; s < N_OUT; s++) begin
      lits = {sec_val, in_pins};
      acc  = 1'b0;
      for (int k = 0; k < PT_PER; k++) begin
        term = 1'b1;
        for (int l = 0; l < N_LIT; l++) begin
          if (active_q[(s*PT_PER+k)*PT_BITS + 2*l]     && !lits[l]) term = 1'b0;
          if (active_q[(s*PT_PER+k)*PT_BITS + 2*l + 1] &&  lits[l]) term = 1'b0;
        end
        acc = acc | term;
      end
      sec_val[s] = acc;
    end
  end

  assign out_pins = sec_val;
endmodule

module pal_fb_array_chk #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int PT_PER = 3
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      cfg_load,
  input logic [N_OUT-1:0]                          out_pins,
  input logic [N_OUT*PT_PER*2*(N_IN+N_OUT)-1:0]    shift_q,
  input logic [N_OUT*PT_PER*2*(N_IN+N_OUT)-1:0]    active_q
);
  localparam int PT_BITS = 2 * (N_IN + N_OUT);
  localparam int N_PT    = N_OUT * PT_PER;

  logic loaded;
  always_ff @(posedge clk) begin
    if (!rst_n)        loaded <= 1'b0;
    else if (cfg_load) loaded <= 1'b1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> out_pins == '0);

  a_r4_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_load) |-> $stable(active_q));

  a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> active_q[2*N_IN-1:0] == $past(shift_q[2*N_IN-1:0]));

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    for (genvar j = p / PT_PER; j < N_OUT; j++) begin : g_fb
      a_r9_no_upward_fb: assert property (@(posedge clk) disable iff (!rst_n)
        active_q[p*PT_BITS + 2*(N_IN+j) +: 2] == 2'b00);
    end
  end
endmodule

bind pal_fb_array pal_fb_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .PT_PER(PT_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .out_pins(out_pins),
  .shift_q(shift_q), .active_q(active_q)
);

// File: tb/pal_fb_array_bench.sv
`timescale 1ns/1ps
module pal_fb_array_bench;
  localparam int CFGW = 192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_shift = 1'b0;
  logic       cfg_din = 1'b0;
  logic       cfg_load = 1'b0;
  logic [3:0] in_pins = '0;
  logic [3:0] out_pins;

  always #2.5 clk = ~clk;

  pal_fb_array u_pal_fb_array (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
    .cfg_load(cfg_load), .in_pins(in_pins), .out_pins(out_pins)
  );

  typedef struct { logic [3:0] exp; logic [3:0] stim; string tag; } item_t;
  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [CFGW-1:0] cfg;

  localparam logic [15:0] W_MT = 16'h3004;
  localparam logic [15:0] X_MT = 16'hFF80;
  localparam logic [15:0] Y_MT = 16'h8DFD;
  localparam logic [15:0] Z_MT = 16'h3106;

  function automatic logic [3:0] ref_out(int idx);
    return {Z_MT[idx], Y_MT[idx], X_MT[idx], W_MT[idx]};
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compared++;
      if (out_pins !== it.exp) begin
        mismatched++;
        $display("FAIL %s in=%b: got %b expected %b", it.tag, it.stim, out_pins, it.exp);
      end
    end
  end

  task automatic apply(input logic [3:0] v, input logic [3:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    in_pins = v;
    it.exp = exp; it.stim = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic lit(input int p, input int l, input bit neg);
    cfg[p*16 + 2*l + int'(neg)] = 1'b1;
  endtask

  task automatic off(input int p);
    cfg[p*16] = 1'b1;
    cfg[p*16 + 1] = 1'b1;
  endtask

  task automatic shift_cfg();
    for (int i = CFGW - 1; i >= 0; i--) begin
      @(posedge clk); #1;
      cfg_shift = 1'b1;
      cfg_din = cfg[i];
    end
    @(posedge clk); #1;
    cfg_shift = 1'b0;
  endtask

  task automatic load_cfg();
    @(posedge clk); #1;
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
  endtask

  // A=3 B=2 C=1 D=0, W feedback literal = 4
  task automatic build_ref();
    cfg = '0;
    lit(0,3,0); lit(0,2,0); lit(0,1,1);
    lit(1,3,1); lit(1,2,1); lit(1,1,0); lit(1,0,1);
    off(2);
    lit(3,3,0);
    lit(4,2,0); lit(4,1,0); lit(4,0,0);
    off(5);
    lit(6,2,1); lit(6,0,1);
    lit(7,3,1); lit(7,2,0);
    lit(8,1,0); lit(8,0,0);
    lit(9,4,0);
    lit(10,3,1); lit(10,2,1); lit(10,1,1); lit(10,0,0);
    lit(11,3,0); lit(11,2,1); lit(11,1,1); lit(11,0,1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset pattern drives every output low
    for (int v = 0; v < 16; v += 5) apply(4'(v), 4'b0000, "R1");

    // R4: shifting without a load leaves outputs at the reset value
    build_ref();
    shift_cfg();
    for (int v = 0; v < 16; v += 5) apply(4'(v), 4'b0000, "R4");

    // R5 + R2/R3 layout + R8 chaining + R10 reference set
    load_cfg();
    for (int v = 0; v < 16; v++) apply(4'(v), ref_out(v), "R10/R2/R3/R8");

    // R4: shift all-ones without load, reference still active
    cfg = '1;
    shift_cfg();
    for (int v = 0; v < 16; v += 3) apply(4'(v), ref_out(v), "R4");

    // R6: every term selects both polarities -> constant 0
    load_cfg();
    for (int v = 0; v < 16; v += 5) apply(4'(v), 4'b0000, "R6 conflict");

    // R6: term with no selects is constant 1
    cfg = '0;
    shift_cfg();
    load_cfg();
    for (int v = 0; v < 16; v += 5) apply(4'(v), 4'b1111, "R6 empty");

    // R7: one always-true term in section 1 lifts only X
    cfg = '0;
    for (int p = 0; p < 12; p++) if (p != 3) off(p);
    shift_cfg();
    load_cfg();
    for (int v = 0; v < 16; v += 5) apply(4'(v), 4'b0010, "R7");

    // R8: Z driven only by W, W = A
    cfg = '0;
    for (int p = 0; p < 12; p++) if (p != 0 && p != 9) off(p);
    lit(0,3,0);
    lit(9,4,0);
    shift_cfg();
    load_cfg();
    for (int v = 0; v < 16; v += 3) apply(4'(v), v[3] ? 4'b1001 : 4'b0000, "R8");

    // R9: self and upward feedback selects are ignored
    build_ref();
    lit(0,4,0); lit(0,5,1); lit(3,7,0); lit(6,6,1); lit(7,7,0); lit(9,7,1);
    shift_cfg();
    load_cfg();
    for (int v = 0; v < 16; v++) apply(4'(v), ref_out(v), "R9");

    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule